// File: doc/BRIEF.md
# Sliding-Window Aligned Input Shifter

This block is the front end of a multi-pattern string matcher. It holds a sliding window of payload characters in a bucket-wide input register. It turns that window into one aligned copy for each pattern slot of a hash bucket row. The window can be filled in one cycle from a parallel load. After that it advances one character per cycle: the newest character enters on the right and the oldest character falls off the left. The window sits right-justified in the register, and every byte to its left is zero.

Each pattern slot of the selected row gets its own copy of the window. Copy `i` is shifted left, in bytes, by the sum of the stored lengths of slots `0` to `i-1`. That places the window where the matcher for that slot compares it against the stored pattern. The slot lengths arrive on a port together with each window update. They go through an adder into an offset register. A single-cycle logarithmic shifter then produces each copy, and a shifted-copy register captures it. A valid flag travels with the copies.

The oldest few characters of the window are also brought out as a key for an external row hash. The hash and the bucket memory are not part of the block.

Top module: `swin_aligner`

## Requirements
- R1: A synchronous active-low reset clears the window, the key, every copy and the valid flag to zero.
- R2: When `load_i` is high, the next edge loads `load_data_i` into the low `WIN_BYTES` bytes of `win_o` and zeros every byte above them. A load takes priority over a shift in the same cycle.
- R3: When `shift_i` is high and `load_i` is low, the next edge places `char_i` in byte 0 (bits 7:0) of `win_o`. Window bytes 0 to `WIN_BYTES-2` move up one byte, the old top window byte is dropped, and the bytes above the window stay zero.
- R4: When neither `load_i` nor `shift_i` is high, `win_o` keeps its value.
- R5: `key_o` equals the `KEY_BYTES` highest window bytes of `win_o` (the oldest characters). The oldest character is in the top byte of `key_o`.
- R6: Copy 0 (bits `ROW_W-1:0` of `copies_o`) equals the window as it was after the update. It appears two edges after the `load_i` or `shift_i` cycle.
- R7: Copy `i` equals that window shifted left by `8*S` bits, where `S` is the sum of the slot lengths 0 to `i-1`. Each length is a 4-bit field, with slot `j` at bits `4j+3:4j` of `row_lens_i`. The lengths are sampled in the same cycle as the `load_i`/`shift_i` request, and zeros fill in from the right.
- R8: When that sum `S` is `BUCKET_BYTES` or more, copy `i` is all zero.
- R9: `copies_valid_o` is high exactly two edges after each cycle with `load_i` or `shift_i` high, and low otherwise.
- R10: While `copies_valid_o` is low, all copies keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load a full window from `load_data_i` |
| shift_i | input | 1 | Advance the window by one character |
| char_i | input | 8 | New payload character for a shift |
| load_data_i | input | WIN_BYTES*8 | Full window for a load, with the oldest character in the top byte |
| row_lens_i | input | SLOTS*LEN_W | Stored pattern lengths of the selected row, slot 0 in the low field |
| win_o | output | BUCKET_BYTES*8 | Window register, right-justified |
| key_o | output | KEY_BYTES*8 | Oldest window characters, used as the hash key |
| copies_o | output | SLOTS*BUCKET_BYTES*8 | Aligned copies, slot 0 in the low bits |
| copies_valid_o | output | 1 | Copies hold a freshly shifted window |

## Verification
A window update, and therefore the key, is due one edge after the request. The aligned copies and their valid flag are due two edges after it. The copies come from the window just updated and the lengths given with the request. The bench applies every input just after a rising edge and samples every output one time unit later. At each edge its reference model first retires the pending copy stage, then applies the new window update. This keeps the one-edge and two-edge results in step with the design's registers.

// File: rtl/swin_pkg.sv
// Package: shared types for the sliding-window aligner.
// Assumes: characters are 8 bits wide.
package swin_pkg;

    typedef logic [7:0] char_t;

    // Window operation chosen in a cycle; a load outranks a shift.
    typedef enum logic [1:0] {
        WOP_HOLD  = 2'd0,
        WOP_SHIFT = 2'd1,
        WOP_LOAD  = 2'd2
    } win_op_e;

endpackage

// File: rtl/swin_window.sv
// Module: swin_window
// Keeps the sliding window right-justified in a BUCKET_BYTES register.
// Assumes BUCKET_BYTES > WIN_BYTES >= 2; bytes above the window stay zero.
module swin_window
    import swin_pkg::*;
#(
    parameter int BUCKET_BYTES = 16,
    parameter int WIN_BYTES    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      shift_i,
    input  char_t                     char_i,
    input  logic [WIN_BYTES*8-1:0]    load_data_i,
    output logic [BUCKET_BYTES*8-1:0] win_o,
    output logic                      upd_o
);

    localparam int ROW_W = BUCKET_BYTES * 8;
    localparam int WIN_W = WIN_BYTES * 8;
    localparam int PAD_W = ROW_W - WIN_W;

    win_op_e           op;
    logic [WIN_W-1:0]  win_q;

    // Decode the requested operation, giving a load priority.
    always_comb begin
        if (load_i)       op = WOP_LOAD;
        else if (shift_i) op = WOP_SHIFT;
        else              op = WOP_HOLD;
    end

    // Window register: load, shift one character, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            case (op)
                WOP_LOAD:  win_q <= load_data_i;
                WOP_SHIFT: win_q <= {win_q[WIN_W-9:0], char_i};
                default:   win_q <= win_q;
            endcase
        end
    end

    assign win_o = {{PAD_W{1'b0}}, win_q};
    assign upd_o = (op != WOP_HOLD);

endmodule

// File: rtl/swin_offset_gen.sv
// Module: swin_offset_gen
// Adds the slot lengths into a running offset for each slot and registers it.
// Assumes the sum of all lengths fits in SUM_W bits; offsets of
// BUCKET_BYTES or more are flagged as blank.
module swin_offset_gen #(
    parameter int BUCKET_BYTES = 16,
    parameter int SLOTS        = 4,
    parameter int LEN_W        = 4,
    parameter int OFF_W        = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic [SLOTS*LEN_W-1:0] lens_i,
    output logic [SLOTS*OFF_W-1:0] off_o,
    output logic [SLOTS-1:0]       blank_o
);

    localparam int SUM_W = LEN_W + $clog2(SLOTS) + 1;

    logic [SUM_W-1:0] run_sum [SLOTS];

    // Running prefix sum of the lengths of all lower slots.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            run_sum[i] = '0;
            for (int j = 0; j < i; j++) begin
                run_sum[i] = run_sum[i] + SUM_W'(lens_i[j*LEN_W +: LEN_W]);
            end
        end
    end

    // Offset and blank registers, one per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_o[g*OFF_W +: OFF_W] <= '0;
                blank_o[g]              <= 1'b0;
            end else if (en_i) begin
                off_o[g*OFF_W +: OFF_W] <= run_sum[g][OFF_W-1:0];
                blank_o[g]              <= (run_sum[g] >= SUM_W'(BUCKET_BYTES));
            end
        end
    end

endmodule

// File: rtl/swin_barrel.sv
// Module: swin_barrel
// Combinational byte-wise left barrel shifter with zero fill.
// Uses log2 stages; a set blank flag forces all-zero output.
module swin_barrel #(
    parameter int BUCKET_BYTES = 16,
    parameter int OFF_W        = 4
) (
    input  logic [BUCKET_BYTES*8-1:0] data_i,
    input  logic [OFF_W-1:0]          amt_i,
    input  logic                      blank_i,
    output logic [BUCKET_BYTES*8-1:0] data_o
);

    // One stage per offset bit; stage s moves by 2**s bytes.
    always_comb begin
        data_o = data_i;
        for (int s = 0; s < OFF_W; s++) begin
            if (amt_i[s]) data_o = data_o << (8 * (1 << s));
        end
        if (blank_i) data_o = '0;
    end

endmodule

// File: rtl/swin_aligner.sv
// Module: swin_aligner (top)
// Stage 1: window update and offset register. Stage 2: one barrel-shifted
// copy per slot, captured in the shifted-copy registers with a valid flag.
// Assumes BUCKET_BYTES is a power of two and KEY_BYTES <= WIN_BYTES < BUCKET_BYTES.
module swin_aligner #(
    parameter int BUCKET_BYTES = 16,
    parameter int WIN_BYTES    = 8,
    parameter int KEY_BYTES    = 4,
    parameter int SLOTS        = 4,
    parameter int LEN_W        = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic                            shift_i,
    input  logic [7:0]                      char_i,
    input  logic [WIN_BYTES*8-1:0]          load_data_i,
    input  logic [SLOTS*LEN_W-1:0]          row_lens_i,
    output logic [BUCKET_BYTES*8-1:0]       win_o,
    output logic [KEY_BYTES*8-1:0]          key_o,
    output logic [SLOTS*BUCKET_BYTES*8-1:0] copies_o,
    output logic                            copies_valid_o
);

    localparam int OFF_W = $clog2(BUCKET_BYTES);
    localparam int ROW_W = BUCKET_BYTES * 8;
    localparam int WIN_W = WIN_BYTES * 8;

    logic                   upd;
    logic                   stage1_vld;
    logic [SLOTS*OFF_W-1:0] off;
    logic [SLOTS-1:0]       blank;

    swin_window #(
        .BUCKET_BYTES(BUCKET_BYTES),
        .WIN_BYTES   (WIN_BYTES)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .shift_i    (shift_i),
        .char_i     (char_i),
        .load_data_i(load_data_i),
        .win_o      (win_o),
        .upd_o      (upd)
    );

    swin_offset_gen #(
        .BUCKET_BYTES(BUCKET_BYTES),
        .SLOTS       (SLOTS),
        .LEN_W       (LEN_W),
        .OFF_W       (OFF_W)
    ) u_offsets (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (upd),
        .lens_i (row_lens_i),
        .off_o  (off),
        .blank_o(blank)
    );

    // Valid pipeline: marks a window update waiting to be shifted, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_vld     <= 1'b0;
            copies_valid_o <= 1'b0;
        end else begin
            stage1_vld     <= upd;
            copies_valid_o <= stage1_vld;
        end
    end

    // One shifter and shifted-copy register per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_copy
        logic [ROW_W-1:0] shifted;

        swin_barrel #(
            .BUCKET_BYTES(BUCKET_BYTES),
            .OFF_W       (OFF_W)
        ) u_barrel (
            .data_i (win_o),
            .amt_i  (off[g*OFF_W +: OFF_W]),
            .blank_i(blank[g]),
            .data_o (shifted)
        );

        // Capture the copy only when a fresh window is in stage 1.
        always_ff @(posedge clk) begin
            if (!rst_n)          copies_o[g*ROW_W +: ROW_W] <= '0;
            else if (stage1_vld) copies_o[g*ROW_W +: ROW_W] <= shifted;
        end
    end

    assign key_o = win_o[WIN_W-1 -: KEY_BYTES*8];

endmodule

// File: rtl/swin_aligner_chk.sv
// Module: swin_aligner_chk
// Assertion checker for swin_aligner, attached with bind.
module swin_aligner_chk #(
    parameter int BUCKET_BYTES = 16,
    parameter int WIN_BYTES    = 8,
    parameter int KEY_BYTES    = 4,
    parameter int SLOTS        = 4,
    parameter int LEN_W        = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            load_i,
    input logic                            shift_i,
    input logic [7:0]                      char_i,
    input logic [WIN_BYTES*8-1:0]          load_data_i,
    input logic [SLOTS*LEN_W-1:0]          row_lens_i,
    input logic [BUCKET_BYTES*8-1:0]       win_o,
    input logic [KEY_BYTES*8-1:0]          key_o,
    input logic [SLOTS*BUCKET_BYTES*8-1:0] copies_o,
    input logic                            copies_valid_o
);

    localparam int ROW_W = BUCKET_BYTES * 8;
    localparam int WIN_W = WIN_BYTES * 8;

    // R2
    load_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (win_o == {{(ROW_W-WIN_W){1'b0}}, $past(load_data_i)}));

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=>
            (win_o[7:0] == $past(char_i)) &&
            (win_o[WIN_W-1:8] == $past(win_o[WIN_W-9:0])) &&
            (win_o[ROW_W-1:WIN_W] == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(win_o));

    // R6
    copy0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copies_valid_o |-> (copies_o[ROW_W-1:0] == $past(win_o)));

    // R9
    valid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i || shift_i) |=> ##1 copies_valid_o);

    // R9
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> ##1 !copies_valid_o);

    // R10
    copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !copies_valid_o |-> $stable(copies_o));

endmodule

bind swin_aligner swin_aligner_chk #(
    .BUCKET_BYTES(BUCKET_BYTES),
    .WIN_BYTES   (WIN_BYTES),
    .KEY_BYTES   (KEY_BYTES),
    .SLOTS       (SLOTS),
    .LEN_W       (LEN_W)
) u_chk (.*);

// File: tb/swin_aligner_tb.sv
module swin_aligner_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BB    = 16;
    localparam int WB    = 8;
    localparam int KB    = 4;
    localparam int SLOTS = 4;
    localparam int LEN_W = 4;
    localparam int ROW_W = BB * 8;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      load_i = 1'b0;
    logic                      shift_i = 1'b0;
    logic [7:0]                char_i = '0;
    logic [WB*8-1:0]           load_data_i = '0;
    logic [SLOTS*LEN_W-1:0]    row_lens_i = '0;
    logic [ROW_W-1:0]          win_o;
    logic [KB*8-1:0]           key_o;
    logic [SLOTS*ROW_W-1:0]    copies_o;
    logic                      copies_valid_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Reference model state
    logic [ROW_W-1:0]       m_win;
    logic [ROW_W-1:0]       m_copy [SLOTS];
    logic                   m_vld;
    logic                   p_vld;
    logic [ROW_W-1:0]       p_win;
    logic [SLOTS*LEN_W-1:0] p_lens;

    always #(CLK_PERIOD/2) clk = ~clk;

    swin_aligner #(
        .BUCKET_BYTES(BB), .WIN_BYTES(WB), .KEY_BYTES(KB),
        .SLOTS(SLOTS), .LEN_W(LEN_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .shift_i(shift_i),
        .char_i(char_i), .load_data_i(load_data_i), .row_lens_i(row_lens_i),
        .win_o(win_o), .key_o(key_o), .copies_o(copies_o),
        .copies_valid_o(copies_valid_o)
    );

    function automatic int lens_sum(input logic [SLOTS*LEN_W-1:0] lens, input int i);
        int s = 0;
        for (int j = 0; j < i; j++) s += int'(lens[j*LEN_W +: LEN_W]);
        return s;
    endfunction

    function automatic logic [ROW_W-1:0] exp_copy(input logic [ROW_W-1:0] w,
                                                  input logic [SLOTS*LEN_W-1:0] lens,
                                                  input int i);
        int s = lens_sum(lens, i);
        if (s >= BB) return '0;
        return w << (8 * s);
    endfunction

    task automatic chk(input string tag, input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic check_all(input string wtag);
        chk(wtag, win_o, m_win);
        chk("R5 key", ROW_W'(key_o), ROW_W'(m_win[WB*8-1 -: KB*8]));
        chk("R9 valid", ROW_W'(copies_valid_o), ROW_W'(m_vld));
        for (int i = 0; i < SLOTS; i++) begin
            string t;
            if (!m_vld)                        t = "R10 copy hold";
            else if (i == 0)                   t = "R6 copy0";
            else if (lens_sum(p_lens, i) >= BB) t = "R8 blank copy";
            else                               t = "R7 shifted copy";
            chk(t, copies_o[i*ROW_W +: ROW_W], m_copy[i]);
        end
    endtask

    task automatic model_reset();
        m_win = '0; m_vld = 1'b0; p_vld = 1'b0; p_win = '0; p_lens = '0;
        for (int i = 0; i < SLOTS; i++) m_copy[i] = '0;
    endtask

    // Apply one cycle of stimulus, advance the model and compare.
    task automatic step(input logic ld, input logic sh, input logic [7:0] ch,
                        input logic [WB*8-1:0] ldd, input logic [SLOTS*LEN_W-1:0] lens);
        string wtag;
        load_i = ld; shift_i = sh; char_i = ch; load_data_i = ldd; row_lens_i = lens;
        @(posedge clk);
        #1;
        // stage 2 retires the pending window
        m_vld = p_vld;
        if (p_vld) for (int i = 0; i < SLOTS; i++) m_copy[i] = exp_copy(p_win, p_lens, i);
        // stage 1 applies the new request
        if (ld) begin
            m_win = ROW_W'(ldd); wtag = "R2 load";
        end else if (sh) begin
            m_win = ROW_W'({m_win[WB*8-9:0], ch}); wtag = "R3 shift";
        end else begin
            wtag = "R4 hold";
        end
        p_vld = ld | sh;
        if (ld | sh) begin
            p_win = m_win; p_lens = lens;
        end
        check_all(wtag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; load_i = 0; shift_i = 0;
        repeat (2) @(posedge clk);
        #1;
        model_reset();
        check_all("R1 reset window");
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        do_reset();

        // Directed: load, lengths 8,8,8,8 -> slot 2 and 3 blank (R8)
        step(1, 0, 8'h00, 64'h0102030405060708, {4'd8, 4'd8, 4'd8, 4'd8});
        step(0, 0, 8'h00, '0, '0);
        step(0, 0, 8'h00, '0, '0);
        // Directed: load and shift together, load wins (R2); zero lengths
        step(1, 1, 8'hEE, 64'hA1A2A3A4A5A6A7A8, '0);
        step(0, 1, 8'h11, '0, {4'd4, 4'd5, 4'd6, 4'd7});
        step(0, 1, 8'h22, '0, {4'd15, 4'd1, 4'd0, 4'd15});
        step(0, 0, 8'h33, '0, '0);
        step(0, 0, 8'h44, '0, '0);
        // Directed: reset in the middle of a run (R1)
        step(1, 0, 8'h00, 64'hFFEEDDCCBBAA9988, {4'd4, 4'd4, 4'd4, 4'd4});
        do_reset();

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [SLOTS*LEN_W-1:0] lens;
            for (int j = 0; j < SLOTS; j++) begin
                if ($urandom_range(0, 9) == 0) lens[j*LEN_W +: LEN_W] = LEN_W'($urandom_range(0, 15));
                else                           lens[j*LEN_W +: LEN_W] = LEN_W'($urandom_range(4, 8));
            end
            step(r < 12, (r >= 8) && (r < 88), 8'($urandom()),
                 {$urandom(), $urandom()}, lens);
        end
        finish_run();
    end

endmodule